// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one W-bit register value (the dividend) by another (the divisor) and returns a W-bit quotient. It uses one restoring shift-and-subtract step per cycle. A caller raises `start_i` for one cycle while the block is idle, and uses `signed_i` to choose between two's-complement and unsigned operands. The block then raises `busy_o` for a fixed number of cycles that depends only on the mode: W+2 cycles for unsigned and W+4 for signed, which is 34 and 36 at the default width of 32. In the last of those cycles it pulses `done_o`, and `quotient_o` holds the result from that cycle until the next operation is accepted. No condition flag is produced or changed.

The control is a six-state machine:
- **IDLE** waits. Its *accept* transition to SETUP fires when `start_i` is high, and it captures both operands and the mode.
- **SETUP** clears the partial remainder and records whether the result needs negating.
  - Its *signed path* transition goes to ABS.
  - Its *unsigned path* transition goes to ITER.
- **ABS** replaces both operands by their magnitudes, then moves to ITER.
- **ITER** runs W shift-subtract steps and leaves on its *last step*.
  - It goes to NEG in signed mode.
  - It goes to DONE in unsigned mode.
- **NEG** two's-complements the quotient when the operand signs differed, then moves to DONE.
- **DONE** pulses `done_o` and takes the *retire* transition back to IDLE.

Top module: `iter_divider`

## Requirements
- R1: In unsigned mode (`signed_i`=1'b0) the quotient equals floor(dividend / divisor), with both operands taken as unsigned W-bit values and the divisor nonzero.
- R2: In signed mode (`signed_i`=1'b1) the quotient equals the two's-complement quotient truncated toward zero, for a nonzero divisor.
- R3: An unsigned operation keeps `busy_o` high for exactly W+2 cycles, counted from the cycle after the accepting clock edge, and `done_o` is high in the last of them.
- R4: A signed operation keeps `busy_o` high for exactly W+4 cycles, and `done_o` is high in the last of them.
- R5: `done_o` is a single-cycle pulse and is high only while `busy_o` is high.
- R6: A `start_i` pulse while `busy_o` is high is ignored: the operation in progress keeps its latency and its quotient.
- R7: An unsigned divide by zero returns all ones and completes in the normal W+2 cycles.
- R8: A signed divide by zero returns all ones for a non-negative dividend and the value 1 for a negative dividend, in the normal W+4 cycles.
- R9: A signed divide of the most negative value by -1 returns the most negative value (bit W-1 set, all other bits clear).
- R10: After reset, `busy_o`, `done_o` and `quotient_o` are all zero.
- R11: After the done cycle, `busy_o` falls and `quotient_o` keeps the result until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a divide; sampled only when idle |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend_i | input | W | Dividend, captured on accept |
| divisor_i | input | W | Divisor, captured on accept |
| quotient_o | output | W | Quotient, valid from the done cycle onward |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of the operation |

## Verification
The assertions check on every cycle that `done_o` is a lone pulse inside `busy_o`, and that a busy machine never re-enters SETUP, so requests arriving mid-operation are dropped. An independent cycle counter checks each done cycle against the mode's fixed latency, and every step with a zero divisor sets its quotient bit. The arithmetic itself can only be shown by the bench's scenarios. These are an exhaustive sweep of every operand pair in both modes on a 4-bit instance, plus directed 32-bit cases: zero divisors, the most-negative-by-minus-one overflow, sign combinations, result holding after done, and a start pulse injected mid-operation.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_ABS,
        S_ITER,
        S_NEG,
        S_DONE
    } div_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SETUP,
        OP_ABS,
        OP_STEP,
        OP_NEG
    } div_op_e;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    signed_i,
    output div_op_e op_o,
    output logic    sgn_o,
    output logic    busy_o,
    output logic    done_o
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] ITER_LAST = CW'(W - 1);
    localparam int LW = $clog2(W + 5);
    localparam logic [LW-1:0] LAT_U = LW'(W + 1);
    localparam logic [LW-1:0] LAT_S = LW'(W + 3);

    div_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            sgn_q;
    logic            accept;

    assign accept = (state_q == S_IDLE) && start_i;
    assign sgn_o  = sgn_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_SETUP;
            S_SETUP: state_d = sgn_q ? S_ABS : S_ITER;
            S_ABS:   state_d = S_ITER;
            S_ITER:  if (cnt_q == ITER_LAST) state_d = sgn_q ? S_NEG : S_DONE;
            S_NEG:   state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sgn_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == S_ITER) ? cnt_q + 1'b1 : '0;
            if (accept) sgn_q <= signed_i;
        end
    end

    // outputs
    always_comb begin
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
        unique case (state_q)
            S_IDLE:  op_o = accept ? OP_LOAD : OP_NONE;
            S_SETUP: op_o = OP_SETUP;
            S_ABS:   op_o = OP_ABS;
            S_ITER:  op_o = OP_STEP;
            S_NEG:   op_o = OP_NEG;
            S_DONE:  op_o = OP_NONE;
            default: op_o = OP_NONE;
        endcase
    end

    // independent latency counter for checking only
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_q <= '0;
        else if (accept)  lat_q <= '0;
        else if (busy_o)  lat_q <= lat_q + 1'b1;
    end

    p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_no_reentry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (state_q != S_SETUP));

    p_latency_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == (sgn_q ? LAT_S : LAT_U)));

endmodule

// File: rtl/div_core.sv
module div_core
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  div_op_e      op_i,
    input  logic         sgn_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quo_o
);

    logic [W-1:0] a_q, b_q, r_q;
    logic         flip_q;
    logic [W:0]   shifted, trial;

    assign shifted = {r_q, a_q[W-1]};
    assign trial   = shifted - {1'b0, b_q};
    assign quo_o   = a_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            r_q    <= '0;
            flip_q <= 1'b0;
        end else begin
            unique case (op_i)
                OP_LOAD: begin
                    a_q <= dividend_i;
                    b_q <= divisor_i;
                end
                OP_SETUP: begin
                    r_q    <= '0;
                    flip_q <= sgn_i & (a_q[W-1] ^ b_q[W-1]);
                end
                OP_ABS: begin
                    if (a_q[W-1]) a_q <= -a_q;
                    if (b_q[W-1]) b_q <= -b_q;
                end
                OP_STEP: begin
                    if (!trial[W]) begin
                        r_q <= trial[W-1:0];
                        a_q <= {a_q[W-2:0], 1'b1};
                    end else begin
                        r_q <= shifted[W-1:0];
                        a_q <= {a_q[W-2:0], 1'b0};
                    end
                end
                OP_NEG: if (flip_q) a_q <= -a_q;
                default: ;
            endcase
        end
    end

    // signed_i is only meaningful to the controller; keep it tied in here
    logic unused_ok;
    assign unused_ok = signed_i;

    p_zero_div_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_STEP && b_q == '0) |=> a_q[0]);

    p_abs_positive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ABS && b_q[W-1] && b_q[W-2:0] != '0) |=> !b_q[W-1]);

endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic         busy_o,
    output logic         done_o
);

    div_op_e op;
    logic    sgn;

    div_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .signed_i (signed_i),
        .op_o     (op),
        .sgn_o    (sgn),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    div_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .sgn_i      (sgn),
        .signed_i   (signed_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quo_o      (quotient_o)
    );

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !done_o);

endmodule

// File: tb/iter_divider_test.sv
module iter_divider_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // 32-bit instance
    logic        st, sg, busy, done;
    logic [31:0] a, b, q;
    iter_divider #(.W(32)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(st), .signed_i(sg),
        .dividend_i(a), .divisor_i(b), .quotient_o(q),
        .busy_o(busy), .done_o(done)
    );

    // 4-bit instance for the exhaustive sweep
    logic       st4, sg4, busy4, done4;
    logic [3:0] a4, b4, q4;
    iter_divider #(.W(4)) uut_small (
        .clk(clk), .rst_n(rst_n), .start_i(st4), .signed_i(sg4),
        .dividend_i(a4), .divisor_i(b4), .quotient_o(q4),
        .busy_o(busy4), .done_o(done4)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref32(input logic [31:0] x, input logic [31:0] y, input bit s);
        longint sx, sy;
        if (y == 0) return (s && x[31]) ? 32'd1 : 32'hFFFF_FFFF;
        if (!s) return x / y;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return 32'(sx / sy);
    endfunction

    function automatic logic [3:0] ref4(input logic [3:0] x, input logic [3:0] y, input bit s);
        int sx, sy;
        if (y == 0) return (s && x[3]) ? 4'd1 : 4'hF;
        if (!s) return x / y;
        sx = int'($signed(x));
        sy = int'($signed(y));
        return 4'(sx / sy);
    endfunction

    task automatic op32(input logic [31:0] x, input logic [31:0] y, input bit s,
                        input bit poke, input string req);
        int n;
        logic [31:0] exp;
        exp = ref32(x, y, s);
        st = 1'b1; sg = s; a = x; b = y;
        @(negedge clk);
        st = 1'b0; a = ~x; b = 32'd3;
        n = 1;
        while (!done && n < 100) begin
            if (poke && n == 5) begin st = 1'b1; sg = ~s; end
            else st = 1'b0;
            @(negedge clk);
            n++;
        end
        st = 1'b0;
        check(n == (s ? 36 : 34), s ? "R4 latency" : "R3 latency", n, s ? 36 : 34);
        check(q == exp, req, q, exp);
        @(negedge clk);
        check(!busy && !done && q == exp, "R11 hold", q, exp);
    endtask

    task automatic op4(input logic [3:0] x, input logic [3:0] y, input bit s);
        int n;
        logic [3:0] exp;
        exp = ref4(x, y, s);
        st4 = 1'b1; sg4 = s; a4 = x; b4 = y;
        @(negedge clk);
        st4 = 1'b0;
        n = 1;
        while (!done4 && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == (s ? 8 : 6), s ? "R4 small latency" : "R3 small latency", n, s ? 8 : 6);
        check(q4 == exp, s ? "R2 sweep" : "R1 sweep", q4, exp);
        @(negedge clk);
        check(!busy4, "R5 busy falls", busy4, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        st = 0; sg = 0; a = 0; b = 0;
        st4 = 0; sg4 = 0; a4 = 0; b4 = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && q == 0, "R10 reset", q, 0);
        check(!busy4 && !done4 && q4 == 0, "R10 reset small", q4, 0);
        rst_n = 1'b1;
        @(negedge clk);

        op32(32'd1000, 32'd7, 1'b0, 1'b0, "R1 basic");
        op32(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R1 max");
        op32(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 big divisor");
        op32(32'd5, 32'd9, 1'b0, 1'b0, "R1 small dividend");
        op32(-32'sd1000, 32'd7, 1'b1, 1'b0, "R2 neg/pos");
        op32(32'd1000, -32'sd7, 1'b1, 1'b0, "R2 pos/neg");
        op32(-32'sd1000, -32'sd7, 1'b1, 1'b0, "R2 neg/neg");
        op32(32'd12345678, 32'd0, 1'b0, 1'b0, "R7 unsigned zero");
        op32(32'd77, 32'd0, 1'b1, 1'b0, "R8 signed zero pos");
        op32(-32'sd77, 32'd0, 1'b1, 1'b0, "R8 signed zero neg");
        op32(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 overflow");
        op32(32'd999, 32'd10, 1'b0, 1'b1, "R6 start ignored unsigned");
        op32(-32'sd999, 32'd10, 1'b1, 1'b1, "R6 start ignored signed");

        for (int s = 0; s < 2; s++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    op4(4'(x), 4'(y), s[0]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // R5: done only ever seen together with busy (sampled away from the edge)
    always @(negedge clk) begin
        if (rst_n && done && !busy) begin
            checks++; fails++;
            $display("FAIL R5 done without busy actual=1 expected=0");
        end
    end

endmodule